// File: doc/BRIEF.md
# Reset Duration Classifier and Sequencer

This block watches an active-low external reset pin, measures how many reference-clock cycles the pin stays low, and turns that length into a decision. Very short glitches change nothing. Pulses of moderate length reset the core while the PLL keeps running. Long pulses also reset the PLL. Before the first valid reset after power-up, only a long pulse is accepted.

After a valid reset the block releases the core a fixed number of cycles after the pin goes high. It then opens the serial host command path after a further fixed delay. It also drives a clock-select output that keeps the core on the reference clock from a PLL reset until the PLL reports lock.

The pin passes through a two-flop synchronizer before it is measured. The block's own power-on reset is `rst_ni`.

Top module: `rst_dur_seq`

## Requirements
- R1: While `rst_ni` is low and right after it is released: `core_rst_o`=1, `pll_rst_o`=1, `core_run_o`=0, `host_ready_o`=0, `clk_sel_ref_o`=1.
- R2: Before the first valid reset, a pin pulse shorter than FULL_MIN (160) cycles is ignored. `core_run_o` stays 0 and `pll_rst_o` stays 1. A pulse of FULL_MIN or more is accepted as a full reset.
- R3: During operation, a pulse shorter than SHORT_MIN (16) cycles is ignored. `core_run_o` and `host_ready_o` stay 1, `pll_rst_o` stays 0 and `clk_sel_ref_o` stays 0.
- R4: During operation, a pulse of SHORT_MIN up to CORE_MAX-1 (16 to 127) cycles resets the core only. `pll_rst_o` never rises and `clk_sel_ref_o` does not change.
- R5: A pulse of CORE_MAX (128) or more cycles, which includes the 128 to 159 gap, raises `pll_rst_o`. `pll_rst_o` falls again two cycles after the pin is first sampled high, and whenever it is 1, `core_rst_o` is also 1.
- R6: `core_run_o` rises, and `core_rst_o` falls, exactly RELEASE_DLY (16) clock edges after the first edge that samples the pin high following a valid reset.
- R7: `host_ready_o` rises exactly HOST_DLY (200) cycles after `core_run_o` rises. It is 0 whenever the core is not running.
- R8: `clk_sel_ref_o` is 1 (reference clock) from a PLL reset until `pll_lock_i` is seen high while `pll_rst_o` is low. One cycle after that it goes to 0. Lock is ignored while `pll_rst_o` is 1.
- R9: The length counter saturates at FULL_MIN, so a pulse far longer than FULL_MIN behaves exactly like a full reset.
- R10: The pin passes through two synchronizer flops. During operation, `core_run_o` falls on the (SHORT_MIN+2)-th clock edge that samples the pin low, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous power-on reset of this block, active low |
| ext_rst_ni | input | 1 | External reset pin, active low, asynchronous to `clk_i` |
| pll_lock_i | input | 1 | PLL lock indication |
| core_rst_o | output | 1 | Core reset, active high |
| pll_rst_o | output | 1 | PLL reset request, active high |
| core_run_o | output | 1 | Core operation enable |
| host_ready_o | output | 1 | Serial host commands may be accepted |
| clk_sel_ref_o | output | 1 | 1 selects the reference clock, 0 the PLL clock |

## Verification
The bench sweeps every pulse length on both sides of each threshold, in a reduced configuration, starting from the running state. It also applies short pulses before the first valid reset. These sweeps catch off-by-one errors at the thresholds: a classifier that is off by one would reset the core on a glitch one cycle too short, or would skip the PLL reset for a pulse exactly at the core-only limit. Release and host-ready edges are checked on their exact cycle, so a missing synchronizer compensation or a host counter that restarts one cycle late shows up as a shifted edge. Lock is dropped during core-only resets, so a design that clears its lock state on every reset would wrongly switch back to the reference clock.

// File: rtl/rst_dur_pkg.sv
package rst_dur_pkg;
  typedef enum logic [1:0] {
    ST_PWRUP = 2'd0,
    ST_HOLD  = 2'd1,
    ST_REL   = 2'd2,
    ST_RUN   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/rst_dur_sync.sv
module rst_dur_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q[g] <= 1'b1;
        else         ff_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q[g] <= 1'b1;
        else         ff_q[g] <= ff_q[g-1];
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/rst_dur_meter.sv
module rst_dur_meter #(
  parameter int unsigned SHORT_MIN = 16,
  parameter int unsigned CORE_MAX  = 128,
  parameter int unsigned FULL_MIN  = 160
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_low_i,
  output logic hit_short_o,
  output logic hit_core_o,
  output logic hit_full_o
);
  localparam int unsigned LW = $clog2(FULL_MIN + 1);

  logic [LW-1:0] len_q, len_d;

  always_comb begin
    if (!pin_low_i)                  len_d = '0;
    else if (len_q == LW'(FULL_MIN)) len_d = len_q;
    else                             len_d = len_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) len_q <= '0;
    else         len_q <= len_d;

  // threshold reached on this edge's low sample
  assign hit_short_o = pin_low_i && (len_q >= LW'(SHORT_MIN - 1));
  assign hit_core_o  = pin_low_i && (len_q >= LW'(CORE_MAX - 1));
  assign hit_full_o  = pin_low_i && (len_q >= LW'(FULL_MIN - 1));

  AST_LEN_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_q <= LW'(FULL_MIN)); // R9
  AST_LEN_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_low_i |=> (len_q == '0)); // R9
endmodule

// File: rtl/rst_dur_fsm.sv
module rst_dur_fsm
  import rst_dur_pkg::*;
#(
  parameter int unsigned RELEASE_DLY = 16,
  parameter int unsigned HOST_DLY    = 200,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_low_i,
  input  logic       hit_short_i,
  input  logic       hit_full_i,
  output seq_state_e state_o,
  output logic       core_rst_o,
  output logic       core_run_o,
  output logic       host_ready_o
);
  // synchronizer latency is part of the release delay
  localparam int unsigned REL_WAIT = RELEASE_DLY - SYNC_STAGES;
  localparam int unsigned DW       = $clog2(REL_WAIT + 1);
  localparam int unsigned HW       = $clog2(HOST_DLY + 1);

  seq_state_e    state_q, state_d;
  logic [DW-1:0] dly_q, dly_d;
  logic [HW-1:0] host_q, host_d;

  always_comb begin
    state_d = state_q;
    dly_d   = dly_q;
    unique case (state_q)
      ST_PWRUP: if (hit_full_i) state_d = ST_HOLD;
      ST_HOLD: begin
        if (!pin_low_i) begin
          state_d = ST_REL;
          dly_d   = '0;
        end
      end
      ST_REL: begin
        if (hit_short_i)                     state_d = ST_HOLD;
        else if (dly_q == DW'(REL_WAIT - 1)) state_d = ST_RUN;
        else                                 dly_d   = dly_q + 1'b1;
      end
      ST_RUN: if (hit_short_i) state_d = ST_HOLD;
      default: state_d = ST_PWRUP;
    endcase
  end

  always_comb begin
    if (state_q != ST_RUN || state_d != ST_RUN) host_d = '0;
    else if (host_q == HW'(HOST_DLY))           host_d = host_q;
    else                                        host_d = host_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= ST_PWRUP;
      dly_q   <= '0;
      host_q  <= '0;
    end else begin
      state_q <= state_d;
      dly_q   <= dly_d;
      host_q  <= host_d;
    end

  assign state_o      = state_q;
  assign core_rst_o   = (state_q != ST_RUN);
  assign core_run_o   = (state_q == ST_RUN);
  assign host_ready_o = (state_q == ST_RUN) && (host_q == HW'(HOST_DLY));

  AST_PWRUP_LONG_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PWRUP && !hit_full_i) |=> (state_q == ST_PWRUP)); // R2
  AST_SHORT_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !hit_short_i) |=> core_run_o); // R3
  AST_RUN_FROM_REL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_run_o) |-> ($past(state_q) == ST_REL)); // R6
  AST_HOST_AFTER_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_ready_o) |-> $past(core_run_o)); // R7
endmodule

// File: rtl/rst_dur_pll.sv
module rst_dur_pll
  import rst_dur_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  seq_state_e state_i,
  input  logic       pin_low_i,
  input  logic       hit_core_i,
  input  logic       pll_lock_i,
  output logic       pll_rst_o,
  output logic       clk_sel_ref_o
);
  logic pll_rst_q, locked_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                                 pll_rst_q <= 1'b1;
    else if (hit_core_i)                         pll_rst_q <= 1'b1;
    else if (state_i == ST_HOLD && !pin_low_i)   pll_rst_q <= 1'b0;

  // lock is sticky until the next PLL reset
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)         locked_q <= 1'b0;
    else if (pll_rst_q)  locked_q <= 1'b0;
    else if (pll_lock_i) locked_q <= 1'b1;

  assign pll_rst_o     = pll_rst_q;
  assign clk_sel_ref_o = !locked_q;

  AST_SEL_AFTER_PLL_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_rst_o |=> clk_sel_ref_o); // R8
  AST_LOCK_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pll_rst_o && clk_sel_ref_o) |=> clk_sel_ref_o); // R8
endmodule

// File: rtl/rst_dur_seq.sv
module rst_dur_seq
  import rst_dur_pkg::*;
#(
  parameter int unsigned SHORT_MIN   = 16,
  parameter int unsigned CORE_MAX    = 128,
  parameter int unsigned FULL_MIN    = 160,
  parameter int unsigned RELEASE_DLY = 16,
  parameter int unsigned HOST_DLY    = 200,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_rst_ni,
  input  logic pll_lock_i,
  output logic core_rst_o,
  output logic pll_rst_o,
  output logic core_run_o,
  output logic host_ready_o,
  output logic clk_sel_ref_o
);
  logic       pin_sync, pin_low;
  logic       hit_short, hit_core, hit_full;
  seq_state_e state;

  rst_dur_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ext_rst_ni),
    .q_o   (pin_sync)
  );

  assign pin_low = !pin_sync;

  rst_dur_meter #(
    .SHORT_MIN(SHORT_MIN),
    .CORE_MAX (CORE_MAX),
    .FULL_MIN (FULL_MIN)
  ) u_meter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_low_i  (pin_low),
    .hit_short_o(hit_short),
    .hit_core_o (hit_core),
    .hit_full_o (hit_full)
  );

  rst_dur_fsm #(
    .RELEASE_DLY(RELEASE_DLY),
    .HOST_DLY   (HOST_DLY),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pin_low_i   (pin_low),
    .hit_short_i (hit_short),
    .hit_full_i  (hit_full),
    .state_o     (state),
    .core_rst_o  (core_rst_o),
    .core_run_o  (core_run_o),
    .host_ready_o(host_ready_o)
  );

  rst_dur_pll u_pll (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .state_i      (state),
    .pin_low_i    (pin_low),
    .hit_core_i   (hit_core),
    .pll_lock_i   (pll_lock_i),
    .pll_rst_o    (pll_rst_o),
    .clk_sel_ref_o(clk_sel_ref_o)
  );

  AST_PLL_WITH_CORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_rst_o |-> core_rst_o); // R5
endmodule

// File: tb/tb_rst_dur_seq.sv
module tb_rst_dur_seq;
  localparam int SM = 4;
  localparam int CM = 10;
  localparam int FM = 14;
  localparam int RD = 6;
  localparam int HD = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ext_rst_ni = 1'b1;
  logic pll_lock_i = 1'b0;
  logic core_rst_o, pll_rst_o, core_run_o, host_ready_o, clk_sel_ref_o;

  int errors = 0;
  int checks = 0;
  int drop_cnt = 0, pll_cnt = 0, sel_cnt = 0, hdrop_cnt = 0;
  logic mon_en = 1'b0;

  always #10 clk = ~clk;

  rst_dur_seq #(
    .SHORT_MIN(SM), .CORE_MAX(CM), .FULL_MIN(FM),
    .RELEASE_DLY(RD), .HOST_DLY(HD), .SYNC_STAGES(2)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .ext_rst_ni(ext_rst_ni), .pll_lock_i(pll_lock_i),
    .core_rst_o(core_rst_o), .pll_rst_o(pll_rst_o), .core_run_o(core_run_o),
    .host_ready_o(host_ready_o), .clk_sel_ref_o(clk_sel_ref_o)
  );

  always @(negedge clk)
    if (mon_en) begin
      if (!core_run_o)   drop_cnt++;
      if (pll_rst_o)     pll_cnt++;
      if (clk_sel_ref_o) sel_cnt++;
      if (!host_ready_o) hdrop_cnt++;
    end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edge_s();
    @(posedge clk);
    #5;
  endtask

  task automatic pulse(input int n, input bit pwr);
    bit valid, full;
    int d0, p0, s0, h0;
    valid = pwr ? (n >= FM) : (n >= SM);
    full  = pwr ? valid : (n >= CM);
    d0 = drop_cnt; p0 = pll_cnt; s0 = sel_cnt; h0 = hdrop_cnt;
    mon_en = 1'b1;
    edge_s();
    pll_lock_i = 1'b0;
    ext_rst_ni = 1'b0;
    for (int i = 1; i <= n; i++) begin
      edge_s();
      if (!pwr && n >= SM + 2) begin
        if (i == SM + 1) chk("R10 run before sync delay", core_run_o, 1);
        if (i == SM + 2) chk("R10 run drop after sync delay", core_run_o, 0);
      end
    end
    ext_rst_ni = 1'b1;
    for (int i = 0; i < RD; i++) edge_s();
    if (valid) chk("R6 run low before release delay", core_run_o, 0);
    edge_s();
    mon_en = 1'b0;
    if (valid) begin
      chk("R6 run at release delay", core_run_o, 1);
      chk("R6 core reset released", core_rst_o, 0);
      chk("R5 pll reset released", pll_rst_o, 0);
      chk("R7 host not ready at run", host_ready_o, 0);
      for (int i = 1; i < HD; i++) edge_s();
      chk("R7 host not ready one cycle early", host_ready_o, 0);
      edge_s();
      chk("R7 host ready after delay", host_ready_o, 1);
    end else if (pwr) begin
      chk("R2 powerup short pulse keeps core off", core_run_o, 0);
      chk("R2 powerup short pulse keeps pll reset", pll_rst_o, 1);
    end else begin
      chk("R3 glitch: core never dropped", drop_cnt - d0, 0);
      chk("R3 glitch: host ready never dropped", hdrop_cnt - h0, 0);
    end
    if (!pwr) begin
      if (full) begin
        chk("R5 pll reset pulsed on long pulse", (pll_cnt - p0) > 0, 1);
        chk("R8 ref clock selected before lock", clk_sel_ref_o, 1);
      end else begin
        chk("R4 pll reset untouched", pll_cnt - p0, 0);
        chk("R4 clock select untouched", sel_cnt - s0, 0);
      end
    end
    pll_lock_i = 1'b1;
    edge_s();
    edge_s();
    if (valid || !pwr) chk("R8 pll clock after lock", clk_sel_ref_o, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #5;
    chk("R1 core reset", core_rst_o, 1);
    chk("R1 pll reset", pll_rst_o, 1);
    chk("R1 run", core_run_o, 0);
    chk("R1 host ready", host_ready_o, 0);
    chk("R1 clock select", clk_sel_ref_o, 1);
    rst_ni = 1'b1;
    edge_s();
    chk("R1 core reset after release", core_rst_o, 1);
    chk("R1 run after release", core_run_o, 0);
    pll_lock_i = 1'b1;
    edge_s();
    edge_s();
    chk("R8 lock ignored during pll reset", clk_sel_ref_o, 1);
    pulse(3, 1'b1);
    pulse(SM, 1'b1);
    pulse(CM, 1'b1);
    pulse(FM - 1, 1'b1);
    pulse(FM, 1'b1);   // R2 first valid reset
    for (int n = 1; n <= FM + 4; n++) pulse(n, 1'b0);
    pulse(4 * FM, 1'b0); // R9 long pulse saturates
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule